// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a synthesizable, cycle-level model of a static RAM with independent read-data and write-data ports. The two ports share one address bus. Every accepted command moves a fixed group of four words. The double-data-rate beats are modelled with a single internal clock that runs at twice the command rate. After reset, the phases alternate: the first edge stands for a rising edge of the main clock (a "K edge") and the next one for its complement (a "K# edge").

Read and write commands are active-low selects. They are sampled only on K edges, and each kind has its own address register. A read delivers its four words on consecutive edges, starting two edges after the command. A write takes its data late, on the four edges that begin two edges after the command, and a per-lane byte mask controls which 9-bit lanes are stored. A request of a kind whose previous burst is still running is dropped. Data presented outside an accepted write burst is discarded. The memory depth is a parameter.

Top module: `qdr_b4_sram`

## Requirements
- R1: A synchronous active-high reset clears `q_vld_o` and `q_o` to zero. The first clock edge with reset low is a K edge, and K and K# edges alternate from then on.
- R2: `rd_n_i` and `wr_n_i` are active low and are sampled only on K edges. If both are low on the same K edge, the read is accepted and the write is ignored.
- R3: Beat k of a burst (k = 0..3) addresses the command address with its low two bits replaced by (low two bits + k) mod 4. The upper address bits never change within a burst.
- R4: A read request on the K edge directly after an accepted read is ignored. A read on the second K edge after an accepted read is accepted, and its beats follow the previous burst with no gap.
- R5: A write request on the K edge directly after an accepted write is ignored, and none of its data is stored.
- R6: A read accepted on edge E places beat k on `q_o` with `q_vld_o` high right after edge E+2+k.
- R7: For a write accepted on edge W, `d_i` and `bw_n_i` are sampled as beat k on edge W+2+k.
- R8: Data and byte masks presented on edges that belong to no accepted write burst leave the memory unchanged.
- R9: On a write beat, `bw_n_i[i]` low stores bits 9i+8..9i of `d_i`. A lane whose bit is high keeps its stored value.
- R10: `q_vld_o` drops right after the last beat of a burst unless a new read continues the stream. It is high only for the four beats of each accepted read.
- R11: When a read beat and a write beat address the same word on the same edge, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_n_i | input | 1 | Active-low read select, sampled on K edges |
| wr_n_i | input | 1 | Active-low write select, sampled on K edges |
| addr_i | input | AW | Shared command address |
| d_i | input | LANE_W*LANES | Write data beat |
| bw_n_i | input | LANES | Active-low byte-lane write mask, one bit per 9-bit lane |
| q_o | output | LANE_W*LANES | Read data beat |
| q_vld_o | output | 1 | High while `q_o` carries a read beat |

## Verification
The bench builds the block with a 5-bit address, which gives eight groups of four words, and keeps the default geometry of four 9-bit lanes. Because the memory is this small, the bench can first fill every group with a known pattern and then hold a complete reference copy. That makes it possible to start bursts at every low-address offset and to catch wrap-around and byte-lane errors on any word. The short depth also lets one run cover back-to-back and dropped commands, writes that collide with reads, and stray data, with every read-back compared against the reference.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;

  localparam int BURST_LEN = 4;
  localparam int BEAT_BITS = 2;

  // Low address bits of beat idx, wrapping inside the aligned group.
  function automatic logic [BEAT_BITS-1:0] beat_lo(input logic [BEAT_BITS-1:0] lo,
                                                   input logic [BEAT_BITS-1:0] idx);
    return lo + idx;
  endfunction

endpackage

// File: rtl/qdr_b4_lane_ram.sv
module qdr_b4_lane_ram #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port, read-first: a same-edge write is not seen by the read.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/qdr_b4_rd_seq.sv
module qdr_b4_rd_seq
  import qdr_b4_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          iss_en,
  output logic [AW-1:0] iss_addr
);

  logic [2:0]           left;
  logic [AW-1:0]        base;
  logic [BEAT_BITS-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      base <= '0;
      idx  <= '0;
    end else if (start) begin
      left <= 3'(BURST_LEN);
      base <= start_addr;
      idx  <= '0;
    end else if (left != '0) begin
      left <= left - 3'd1;
      idx  <= idx + 2'd1;
    end
  end

  assign iss_en   = (left != '0);
  assign busy     = (left > 3'd1);
  assign iss_addr = {base[AW-1:BEAT_BITS], beat_lo(base[BEAT_BITS-1:0], idx)};

  AST_RD_ISSUE_NEXT: assert property (@(posedge clk) disable iff (rst)
    start |=> iss_en); // R6
  AST_RD_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst)
    left <= 3'(BURST_LEN)); // R2

endmodule

// File: rtl/qdr_b4_wr_seq.sv
module qdr_b4_wr_seq
  import qdr_b4_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          commit_en,
  output logic [AW-1:0] commit_addr
);

  logic                 hold;
  logic [AW-1:0]        hold_addr;
  logic [2:0]           left;
  logic [AW-1:0]        base;
  logic [BEAT_BITS-1:0] idx;

  // Command stage: holds the address across the K# edge before data starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= 1'b0;
      hold_addr <= '0;
    end else if (start) begin
      hold      <= 1'b1;
      hold_addr <= start_addr;
    end else begin
      hold      <= 1'b0;
    end
  end

  // Beat stage: one data beat committed per edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      base <= '0;
      idx  <= '0;
    end else if (hold) begin
      left <= 3'(BURST_LEN);
      base <= hold_addr;
      idx  <= '0;
    end else if (left != '0) begin
      left <= left - 3'd1;
      idx  <= idx + 2'd1;
    end
  end

  assign commit_en   = (left != '0);
  assign busy        = hold | (left > 3'd2);
  assign commit_addr = {base[AW-1:BEAT_BITS], beat_lo(base[BEAT_BITS-1:0], idx)};

  AST_WR_LATE_BEAT: assert property (@(posedge clk) disable iff (rst)
    start |=> ##1 commit_en); // R7
  AST_WR_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
    hold |=> !hold); // R5

endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_n_i,
  input  logic                    wr_n_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANE_W*LANES-1:0] d_i,
  input  logic [LANES-1:0]        bw_n_i,
  output logic [LANE_W*LANES-1:0] q_o,
  output logic                    q_vld_o
);

  localparam int DW = LANE_W * LANES;

  logic          kph;
  logic          k_edge;
  logic          rd_go, wr_go;
  logic          rd_busy, wr_busy;
  logic          rd_iss, wr_commit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] ram_q;
  logic          ram_vld;
  logic [1:0]    vcnt;

  // Phase of the double-rate clock: 0 means the coming edge is a K edge.
  always_ff @(posedge clk) begin
    if (rst) kph <= 1'b0;
    else     kph <= ~kph;
  end
  assign k_edge = ~kph;

  // Read has priority over a write on the same K edge.
  assign rd_go = k_edge & ~rd_n_i & ~rd_busy;
  assign wr_go = k_edge & ~wr_n_i & rd_n_i & ~wr_busy;

  qdr_b4_rd_seq #(.AW(AW)) u_rd_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (rd_go),
    .start_addr (addr_i),
    .busy       (rd_busy),
    .iss_en     (rd_iss),
    .iss_addr   (rd_addr)
  );

  qdr_b4_wr_seq #(.AW(AW)) u_wr_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (wr_go),
    .start_addr  (addr_i),
    .busy        (wr_busy),
    .commit_en   (wr_commit),
    .commit_addr (wr_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qdr_b4_lane_ram #(.AW(AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .we    (wr_commit & ~bw_n_i[l]),
      .waddr (wr_addr),
      .wdata (d_i[l*LANE_W +: LANE_W]),
      .re    (rd_iss),
      .raddr (rd_addr),
      .rdata (ram_q[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_vld <= 1'b0;
      q_vld_o <= 1'b0;
      q_o     <= '0;
    end else begin
      ram_vld <= rd_iss;
      q_vld_o <= ram_vld;
      if (ram_vld) q_o <= ram_q;
    end
  end

  // Beat counter used only by the burst-length check.
  always_ff @(posedge clk) begin
    if (rst)          vcnt <= '0;
    else if (q_vld_o) vcnt <= vcnt + 2'd1;
  end

  AST_RD_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> ##2 q_vld_o); // R6
  AST_RD_REJECT_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> ##1 !rd_go); // R4
  AST_WR_REJECT_NEXT: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> ##1 !wr_go); // R5
  AST_WHOLE_BURSTS: assert property (@(posedge clk) disable iff (rst)
    $fell(q_vld_o) |-> (vcnt == 2'd0)); // R10
  AST_CMD_ON_K: assert property (@(posedge clk) disable iff (rst)
    (rd_go || wr_go) |=> !(rd_go || wr_go)); // R1

endmodule

// File: tb/test_qdr_b4_sram.sv
module test_qdr_b4_sram;

  localparam int AW     = 5;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int DW     = LANE_W * LANES;
  localparam int WORDS  = 1 << AW;

  typedef struct {
    int            cyc;
    logic [DW-1:0] data;
    string         tag;
  } exp_item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    din = '0;
  logic [LANES-1:0] bwn = '1;
  logic [DW-1:0]    q;
  logic             q_vld;

  int        cyc = 0;
  int        checks = 0;
  int        fails = 0;
  bit        done = 1'b0;
  exp_item_t exp_q[$];
  exp_item_t it;
  logic [DW-1:0] ref_mem [WORDS];

  always #4 clk = ~clk;

  qdr_b4_sram #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) i_qdr_b4_sram (
    .clk     (clk),
    .rst     (rst),
    .rd_n_i  (rd_n),
    .wr_n_i  (wr_n),
    .addr_i  (addr),
    .d_i     (din),
    .bw_n_i  (bwn),
    .q_o     (q),
    .q_vld_o (q_vld)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [DW-1:0] pat(input int n);
    return {9'(n*7+1), 9'(n*13+2), 9'(n*29+3), 9'(n*31+5)};
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // One edge of stimulus; called and returning at a falling edge.
  task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [LANES-1:0] bw);
    rd_n = r; wr_n = w; addr = a; din = d; bwn = bw;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, pat(900 + i), '0);
  endtask

  // K edges come when the count seen at a falling edge is even.
  task automatic align_k();
    if (cyc % 2 != 0) idle(1);
  endtask

  task automatic push_read(input logic [AW-1:0] a, input string tag);
    for (int k = 0; k < 4; k++) begin
      exp_item_t e;
      e.cyc  = cyc + 3 + k;
      e.data = ref_mem[beat_addr(a, k)];
      e.tag  = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic rd_cmd(input logic [AW-1:0] a, input bit accepted, input string tag);
    align_k();
    if (accepted) push_read(a, tag);
    step(1'b0, 1'b1, a, pat(800), '0);
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input int seed, input logic [15:0] bwv,
                          input bit poke, input logic [AW-1:0] poke_addr);
    align_k();
    step(1'b1, 1'b0, a, pat(700), '0);
    step(1'b1, 1'b1, a, pat(701), '0);
    for (int k = 0; k < 4; k++) begin
      logic [LANES-1:0] m = bwv[4*k +: 4];
      logic [AW-1:0]    ak = beat_addr(a, k);
      for (int l = 0; l < LANES; l++)
        if (!m[l]) ref_mem[ak][l*LANE_W +: LANE_W] = pat(seed + k)[l*LANE_W +: LANE_W];
      if (k == 0 && poke) step(1'b1, 1'b0, poke_addr, pat(seed + k), m);
      else                step(1'b1, 1'b1, a, pat(seed + k), m);
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() != 0 && exp_q[0].cyc == cyc) begin
        it = exp_q.pop_front();
        checks++;
        if (!(q_vld === 1'b1 && q === it.data)) begin
          fails++;
          $display("FAIL %s beat at cycle %0d: actual vld=%b q=%h expected vld=1 q=%h",
                   it.tag, cyc, q_vld, q, it.data);
        end
      end else if (q_vld !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R10 unexpected beat at cycle %0d: actual vld=1 q=%h expected vld=0", cyc, q);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(q_vld === 1'b0, "R1", "valid in reset", {35'd0, q_vld}, '0);
    check(q === '0, "R1", "data in reset", q, '0);
    rst = 1'b0;

    // Fill every group with full-mask bursts (R7, R9).
    for (int g = 0; g < WORDS / 4; g++) wr_burst(AW'(g * 4), 10 * g, 16'h0000, 1'b0, '0);
    idle(2);

    // Plain reads and offset-start wrap (R6, R3).
    rd_cmd(AW'(0), 1'b1, "R6");
    idle(4);
    rd_cmd(AW'(4 + 2), 1'b1, "R3");
    idle(6);

    // Back-to-back reads two K edges apart stream without gaps (R4).
    rd_cmd(AW'(8), 1'b1, "R4");
    idle(3);
    rd_cmd(AW'(12 + 1), 1'b1, "R4");
    idle(8);

    // Read on the very next K edge is dropped (R4).
    rd_cmd(AW'(16), 1'b1, "R4");
    rd_cmd(AW'(20), 1'b0, "R4");
    idle(8);

    // Write starting at low bits 3 wraps inside its group (R3, R7).
    wr_burst(AW'(24 + 3), 200, 16'h0000, 1'b0, '0);
    idle(2);
    rd_cmd(AW'(24 + 1), 1'b1, "R3");
    idle(6);

    // Byte lanes: beat masks all, none, lanes 1 and 3, lane 0 (R9).
    wr_burst(AW'(28), 300, {4'b1110, 4'b0101, 4'b1111, 4'b0000}, 1'b0, '0);
    idle(2);
    rd_cmd(AW'(28), 1'b1, "R9");
    idle(6);

    // Second write on the next K edge is dropped, stray data after it too (R5, R8).
    wr_burst(AW'(20 + 1), 400, 16'h0000, 1'b1, AW'(16));
    step(1'b1, 1'b1, AW'(16), pat(500), '0);
    step(1'b1, 1'b1, AW'(16), pat(501), '0);
    idle(2);
    rd_cmd(AW'(16), 1'b1, "R5");
    idle(3);
    rd_cmd(AW'(20), 1'b1, "R5");
    idle(8);

    // Read and write on the same K edge: read wins, write data dropped (R2).
    align_k();
    push_read(AW'(12), "R2");
    step(1'b0, 1'b0, AW'(12), pat(600), '0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, AW'(12), pat(601 + i), '0);
    idle(2);
    rd_cmd(AW'(12), 1'b1, "R2");
    idle(6);

    // Stray data with writes deselected is discarded (R8).
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, AW'(i), pat(650 + i), '0);
    rd_cmd(AW'(0), 1'b1, "R8");
    idle(6);

    // Collision: write beat 0 lands on the word read by beat 3 (R11).
    rd_cmd(AW'(8), 1'b1, "R11");
    wr_burst(AW'(8 + 3), 700, 16'h0000, 1'b0, '0);
    idle(2);
    rd_cmd(AW'(8), 1'b1, "R11");
    idle(10);

    check(exp_q.size() == 0, "R6", "beats left unseen", DW'(exp_q.size()), '0);
    check(q_vld === 1'b0, "R10", "valid after final burst", {35'd0, q_vld}, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule